// File: doc/BRIEF.md
# Multiphase Current Sample Sequencer

This block shares a single 6-bit current converter among up to six power-stage phases. Each phase has an on-time start pulse. When the block sees the rising edge of that pulse, it counts a programmable number of clock cycles, so that the conversion falls near the middle of the phase's on-time. It then selects the phase on the converter's input multiplexer, issues a one-cycle start request, and waits for the converter's done strobe. The returned 6-bit code goes into that phase's result register, and a one-cycle valid strobe tagged with the phase index reports it. One LSB of the code is about 4.3 µA of sense current, which gives a full scale of about 0 to 275 µA.

Requests from several phases can fall due while the converter is busy. These are queued and served lowest phase first, and none is lost. A phase whose next on-time start arrives before its previous sample was converted loses the stale request and raises a sticky overrun flag. The block also holds the 2-bit code that sets the sense-input offset voltage.

Top module: `cur_sample_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `adc_start`, `res_valid` and `overrun` are 0, every result slice is 0, and `offset_code` is 00.
- R2: `offset_code` encodes the sense offset as 00 = 25 mV, 01 = 50 mV, 10 = 75 mV, 11 = 100 mV. A clock edge with `offset_we` high loads `offset_din`. Without `offset_we` the value does not change.
- R3: Let the first clock edge that samples `ton_start[i]` high (after it was low) be edge k, with phase i enabled and the converter idle. Then `adc_start` is high after edge k+`delay_cfg`+2, with `adc_sel` = i.
- R4: `adc_start` is high for exactly one cycle per conversion. `adc_sel` holds the phase index from that cycle until `adc_done` arrives.
- R5: When `adc_done` is sampled, `adc_data` is written to bits [6i+5:6i] of `res_data` for the selected phase i. On the next cycle `res_valid` is high for one cycle with `res_phase` = i.
- R6: Requests that fall due while the converter is busy are all kept. They are converted in ascending phase-index order, and each start edge gives exactly one conversion.
- R7: A new rising edge on `ton_start[i]` while phase i is still counting or waiting for the converter drops the old request. It restarts the delay and sets `overrun[i]`, which stays 1 until reset.
- R8: A phase whose `enable_mask` bit is 0 is never converted. Its result slice keeps its last value, and clearing the bit discards any request in progress for that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_mask | input | NPH | Per-phase sampling enable |
| delay_cfg | input | DLY_W | Sampling delay in clock cycles after the on-time start |
| ton_start | input | NPH | Per-phase on-time start pulses |
| offset_we | input | 1 | Load strobe for the offset code |
| offset_din | input | 2 | New offset code |
| offset_code | output | 2 | Current sense-input offset code |
| adc_start | output | 1 | One-cycle conversion request |
| adc_sel | output | 3 | Multiplexer phase select |
| adc_done | input | 1 | Converter completion strobe |
| adc_data | input | 6 | Converter result code |
| res_data | output | NPH*6 | Per-phase result registers, phase i at [6i+5:6i] |
| res_valid | output | 1 | One-cycle result strobe |
| res_phase | output | 3 | Phase index of the result being reported |
| overrun | output | NPH | Sticky per-phase overrun flags |

## Verification
Starting from the edge that first samples an on-time start high, the conversion request is due `delay_cfg`+2 cycles later. A result strobe follows one cycle after the edge that samples `adc_done`, and an offset write is visible one cycle after its edge. The bench counts falling edges from the start pulse and requires the request to appear exactly on the expected one. It samples every output on the falling edge between the clock edges. A scoreboard queue, filled by the driver in the order the conversions should happen, is matched against each result strobe as it arrives, so reordering, loss and an extra conversion each show up as a mismatch.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int MAX_PH   = 8;
    localparam int PH_IDX_W = 3;
    localparam int CODE_W   = 6;

    typedef logic [PH_IDX_W-1:0] ph_idx_t;
    typedef logic [CODE_W-1:0]   code_t;

    typedef enum logic [1:0] {
        OFS_25MV  = 2'b00,
        OFS_50MV  = 2'b01,
        OFS_75MV  = 2'b10,
        OFS_100MV = 2'b11
    } ofs_code_e;

    typedef enum logic {
        CV_IDLE = 1'b0,
        CV_BUSY = 1'b1
    } conv_state_e;

    typedef struct packed {
        ph_idx_t ph;
        code_t   code;
    } sample_t;

    // lowest set bit of a padded request vector
    function automatic ph_idx_t lowest_req(input logic [MAX_PH-1:0] v);
        ph_idx_t r;
        r = '0;
        for (int i = MAX_PH - 1; i >= 0; i--) begin
            if (v[i]) r = ph_idx_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/cs_phase_timer.sv
module cs_phase_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ton,
    input  logic [DLY_W-1:0] dly,
    input  logic             take,
    output logic             req,
    output logic             ovr
);
    logic             ton_q;
    logic             counting;
    logic             pend;
    logic [DLY_W-1:0] cnt;
    logic             rise;
    logic             stale;

    assign rise  = ton & ~ton_q;
    assign stale = counting | (pend & ~take);
    assign req   = pend & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ton_q    <= 1'b0;
            counting <= 1'b0;
            pend     <= 1'b0;
            cnt      <= '0;
            ovr      <= 1'b0;
        end else begin
            ton_q <= ton;
            if (!en) begin
                counting <= 1'b0;
                pend     <= 1'b0;
            end else if (rise) begin
                if (stale) ovr <= 1'b1;
                counting <= 1'b1;
                cnt      <= dly;
                pend     <= 1'b0;
            end else if (take) begin
                pend <= 1'b0;
            end else if (counting) begin
                if (cnt == '0) begin
                    counting <= 1'b0;
                    pend     <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cs_req_picker.sv
module cs_req_picker
    import cs_pkg::*;
#(
    parameter int NPH = 6
) (
    input  logic [NPH-1:0] req,
    output logic           any,
    output ph_idx_t        idx
);
    logic [MAX_PH-1:0] padded;

    assign padded = {{(MAX_PH-NPH){1'b0}}, req};
    assign any    = |req;
    assign idx    = lowest_req(padded);
endmodule

// File: rtl/cs_result_bank.sv
module cs_result_bank
    import cs_pkg::*;
#(
    parameter int NPH = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  sample_t               wr_s,
    output logic [NPH*CODE_W-1:0] data,
    output logic                  valid,
    output ph_idx_t               phase
);
    for (genvar g = 0; g < NPH; g++) begin : g_slot
        code_t slot;
        always_ff @(posedge clk) begin
            if (rst)                               slot <= '0;
            else if (wr && wr_s.ph == ph_idx_t'(g)) slot <= wr_s.code;
        end
        assign data[g*CODE_W +: CODE_W] = slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            phase <= '0;
        end else begin
            valid <= wr;
            if (wr) phase <= wr_s.ph;
        end
    end
endmodule

// File: rtl/cur_sample_seq.sv
module cur_sample_seq
    import cs_pkg::*;
#(
    parameter int NPH   = 6,
    parameter int DLY_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPH-1:0]        enable_mask,
    input  logic [DLY_W-1:0]      delay_cfg,
    input  logic [NPH-1:0]        ton_start,
    input  logic                  offset_we,
    input  logic [1:0]            offset_din,
    output logic [1:0]            offset_code,
    output logic                  adc_start,
    output logic [PH_IDX_W-1:0]   adc_sel,
    input  logic                  adc_done,
    input  logic [CODE_W-1:0]     adc_data,
    output logic [NPH*CODE_W-1:0] res_data,
    output logic                  res_valid,
    output logic [PH_IDX_W-1:0]   res_phase,
    output logic [NPH-1:0]        overrun
);
    conv_state_e    state;
    ph_idx_t        sel_q;
    logic           start_q;
    ofs_code_e      ofs_q;
    logic [NPH-1:0] req_vec;
    logic [NPH-1:0] take_vec;
    logic           any_req;
    ph_idx_t        pick_idx;
    logic           grant;
    logic           store;
    sample_t        wr_s;

    assign grant = (state == CV_IDLE) && any_req;

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        assign take_vec[p] = grant && (pick_idx == ph_idx_t'(p));
        cs_phase_timer #(.DLY_W(DLY_W)) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .en   (enable_mask[p]),
            .ton  (ton_start[p]),
            .dly  (delay_cfg),
            .take (take_vec[p]),
            .req  (req_vec[p]),
            .ovr  (overrun[p])
        );
    end

    cs_req_picker #(.NPH(NPH)) u_pick (
        .req (req_vec),
        .any (any_req),
        .idx (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CV_IDLE;
            sel_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                CV_IDLE: if (any_req) begin
                    state   <= CV_BUSY;
                    sel_q   <= pick_idx;
                    start_q <= 1'b1;
                end
                CV_BUSY: if (adc_done) state <= CV_IDLE;
                default: state <= CV_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            ofs_q <= OFS_25MV;
        else if (offset_we) ofs_q <= ofs_code_e'(offset_din);
    end

    assign store   = (state == CV_BUSY) && adc_done;
    assign wr_s.ph   = sel_q;
    assign wr_s.code = adc_data;

    cs_result_bank #(.NPH(NPH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (store),
        .wr_s  (wr_s),
        .data  (res_data),
        .valid (res_valid),
        .phase (res_phase)
    );

    assign offset_code = ofs_q;
    assign adc_start   = start_q;
    assign adc_sel     = sel_q;
endmodule

// File: rtl/cs_sample_seq_chk.sv
module cs_sample_seq_chk #(
    parameter int NPH = 6
) (
    input logic           clk,
    input logic           rst,
    input logic [NPH-1:0] enable_mask,
    input logic           offset_we,
    input logic [1:0]     offset_code,
    input logic           adc_start,
    input logic [2:0]     adc_sel,
    input logic           adc_done,
    input logic           res_valid,
    input logic [2:0]     res_phase,
    input logic [NPH-1:0] overrun
);
    logic [NPH-1:0] mask_q;
    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= enable_mask;
    end

    assert_ofs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !offset_we |=> $stable(offset_code));
    assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> $stable(adc_sel));
    assert_valid_after_done_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(adc_done));
    assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (32'(res_phase) < NPH));
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ((overrun & $past(overrun)) == $past(overrun)));
    assert_masked_never_R8: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> mask_q[adc_sel]);
endmodule

bind cur_sample_seq cs_sample_seq_chk #(.NPH(NPH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable_mask (enable_mask),
    .offset_we   (offset_we),
    .offset_code (offset_code),
    .adc_start   (adc_start),
    .adc_sel     (adc_sel),
    .adc_done    (adc_done),
    .res_valid   (res_valid),
    .res_phase   (res_phase),
    .overrun     (overrun)
);

// File: tb/tb_cur_sample_seq.sv
module tb_cur_sample_seq;
    localparam int NPH = 6;
    localparam int DLY_W = 8;
    localparam int LAT = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic [NPH-1:0]   enable_mask;
    logic [DLY_W-1:0] delay_cfg;
    logic [NPH-1:0]   ton_start;
    logic             offset_we;
    logic [1:0]       offset_din;
    logic [1:0]       offset_code;
    logic             adc_start;
    logic [2:0]       adc_sel;
    logic             adc_done;
    logic [5:0]       adc_data;
    logic [NPH*6-1:0] res_data;
    logic             res_valid;
    logic [2:0]       res_phase;
    logic [NPH-1:0]   overrun;

    int total = 0;
    int bad = 0;
    int exp_n = 0;
    int conv_n = 0;
    int valid_cnt = 0;
    int q_ph[$];
    int q_code[$];
    int last_code[NPH];

    always #5 clk = ~clk;

    cur_sample_seq #(.NPH(NPH), .DLY_W(DLY_W)) dut (
        .clk(clk), .rst(rst), .enable_mask(enable_mask), .delay_cfg(delay_cfg),
        .ton_start(ton_start), .offset_we(offset_we), .offset_din(offset_din),
        .offset_code(offset_code), .adc_start(adc_start), .adc_sel(adc_sel),
        .adc_done(adc_done), .adc_data(adc_data), .res_data(res_data),
        .res_valid(res_valid), .res_phase(res_phase), .overrun(overrun)
    );

    function automatic int code_for(int ph, int n);
        return (ph * 11 + n * 7 + 3) % 64;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_exp(int ph);
        q_ph.push_back(ph);
        q_code.push_back(code_for(ph, exp_n));
        exp_n++;
    endtask

    task automatic pulse(logic [NPH-1:0] m);
        @(negedge clk) ton_start = m;
        @(negedge clk) ton_start = '0;
    endtask

    // converter model
    initial begin
        adc_done = 1'b0;
        adc_data = '0;
        forever begin
            @(negedge clk);
            if (adc_start) begin
                automatic int s = int'(adc_sel);
                repeat (LAT) @(negedge clk);
                adc_done = 1'b1;
                adc_data = 6'(code_for(s, conv_n));
                conv_n++;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && res_valid) begin
                valid_cnt++;
                if (q_ph.size() == 0) begin
                    chk(1'b0, "R6 unexpected result", int'(res_phase), -1);
                end else begin
                    automatic int ep = q_ph.pop_front();
                    automatic int ec = q_code.pop_front();
                    chk(int'(res_phase) == ep, "R6 order", int'(res_phase), ep);
                    chk(int'(res_data[ep*6 +: 6]) == ec, "R5 stored code",
                        int'(res_data[ep*6 +: 6]), ec);
                    last_code[ep] = ec;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k;
        int v0;
        for (int i = 0; i < NPH; i++) last_code[i] = 0;
        rst = 1'b1; enable_mask = '1; delay_cfg = 8'd5; ton_start = '0;
        offset_we = 1'b0; offset_din = 2'b00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(adc_start == 0 && res_valid == 0, "R1 strobes", int'(adc_start), 0);
        chk(overrun == 0, "R1 overrun", int'(overrun), 0);
        chk(res_data == 0, "R1 results", int'(res_data != 0), 0);
        chk(offset_code == 2'b00, "R1 offset", int'(offset_code), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_start == 0 && overrun == 0, "R1 after release", int'(adc_start), 0);

        // R2 offset code write and hold
        offset_din = 2'b10; offset_we = 1'b1;
        @(negedge clk) offset_we = 1'b0; offset_din = 2'b01;
        chk(offset_code == 2'b10, "R2 write 75mV", int'(offset_code), 2);
        repeat (2) @(negedge clk);
        chk(offset_code == 2'b10, "R2 hold", int'(offset_code), 2);
        offset_din = 2'b11; offset_we = 1'b1;
        @(negedge clk) offset_we = 1'b0;
        chk(offset_code == 2'b11, "R2 write 100mV", int'(offset_code), 3);

        // R3 delay timing, single phase
        push_exp(2);
        ton_start = 6'b000100;
        @(negedge clk) ton_start = '0;
        k = 1;
        while (!adc_start && k < 300) begin
            @(negedge clk);
            k++;
        end
        chk(k == 5 + 3, "R3 start delay", k, 8);
        chk(adc_sel == 3'd2, "R3 select", int'(adc_sel), 2);
        @(negedge clk);
        chk(adc_start == 0, "R4 single pulse", int'(adc_start), 0);
        repeat (20) @(negedge clk);

        // R3 with another delay value
        delay_cfg = 8'd12;
        push_exp(5);
        ton_start = 6'b100000;
        @(negedge clk) ton_start = '0;
        k = 1;
        while (!adc_start && k < 300) begin
            @(negedge clk);
            k++;
        end
        chk(k == 12 + 3, "R3 start delay 12", k, 15);
        repeat (20) @(negedge clk);

        // R6 all phases at once, ascending order, none lost
        delay_cfg = 8'd4;
        for (int p = 0; p < NPH; p++) push_exp(p);
        pulse(6'b111111);
        repeat (80) @(negedge clk);
        chk(q_ph.size() == 0, "R6 all served", q_ph.size(), 0);
        chk(overrun == 0, "R7 no overrun", int'(overrun), 0);

        // R7 overrun: restart before conversion
        delay_cfg = 8'd20;
        v0 = valid_cnt;
        push_exp(1);
        pulse(6'b000010);
        repeat (4) @(negedge clk);
        pulse(6'b000010);
        repeat (60) @(negedge clk);
        chk(overrun == 6'b000010, "R7 flag", int'(overrun), 2);
        chk(valid_cnt - v0 == 1, "R7 single conversion", valid_cnt - v0, 1);
        pulse(6'b000001);
        push_exp(0);
        repeat (40) @(negedge clk);
        chk(overrun == 6'b000010, "R7 sticky", int'(overrun), 2);

        // R8 masked phase
        delay_cfg = 8'd3;
        enable_mask = 6'b110111;
        v0 = valid_cnt;
        push_exp(4);
        pulse(6'b011000);
        repeat (40) @(negedge clk);
        chk(valid_cnt - v0 == 1, "R8 masked skipped", valid_cnt - v0, 1);
        chk(int'(res_data[3*6 +: 6]) == last_code[3], "R8 slice kept",
            int'(res_data[3*6 +: 6]), last_code[3]);
        // disable while counting discards the request
        enable_mask = '1;
        delay_cfg = 8'd10;
        v0 = valid_cnt;
        pulse(6'b001000);
        repeat (3) @(negedge clk);
        enable_mask = 6'b110111;
        repeat (3) @(negedge clk);
        enable_mask = '1;
        repeat (40) @(negedge clk);
        chk(valid_cnt - v0 == 0, "R8 disable drops", valid_cnt - v0, 0);
        chk(q_ph.size() == 0, "R6 queue empty", q_ph.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule